// File: doc/BRIEF.md
# Write-First Simple Dual-Port Memory

This block is a memory with one port that only writes and one port that only reads, both on the same clock. The read port has a registered output. When a write and a read hit the same address in the same cycle, the read returns the value being written. That is the write-first result, and it appears on the same edge as the write.

The forwarding uses no multiplexer after the output register. The write data bus is wired to the data inputs of both storage ports. When the addresses match, the read port is also given a write strobe. Both ports then store the same word into the same location, which is a legal case. The read port runs in write-first mode, so its own output register loads that word directly. The address compare sits on the set-up path into the storage, and the clock-to-output path stays as short as a plain registered read.

A typical use is a stack or register store inside a non-pipelined processor. There, the word written on one edge may be needed on the same edge or on the next one.

Top module: `wf_sdp_mem`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled read, `rd_data` is all zeros.
- R2: On a rising edge with `wr_en` high, `wr_data` is stored at `wr_addr`. A later enabled read of that address returns it.
- R3: On a rising edge with `rd_en` high and no write to `rd_addr` in that cycle, `rd_data` takes the stored content of `rd_addr` one cycle after the address is presented.
- R4: On a rising edge with `rd_en` and `wr_en` both high and `rd_addr` equal to `wr_addr`, `rd_data` takes `wr_data` on that same edge, and the location also holds `wr_data` for later reads.
- R5: A cycle with `wr_en` low changes no stored word, whatever `wr_addr` and `wr_data` carry.
- R6: A cycle with `rd_en` low leaves `rd_data` unchanged, including when a write hits the address on `rd_addr`.
- R7: A read issued in the cycle right after a write to the same address returns the newly written word.
- R8: A write to one address during an enabled read of a different address does not disturb the read result, which is the stored content of the read address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read output register |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read enable; low holds `rd_data` |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Registered read result |

## Verification
The hardest case to reach is a write and an enabled read that collide on one address in the same cycle, together with its neighbours. Those neighbours are the same-address write while the read is disabled, and the read issued one cycle after a write. The stimulus produces these cases on purpose in dedicated phases. It then runs a long random phase with addresses drawn from only four locations, so that collisions, back-to-back reuse and idle-read overlaps happen many times in varied order. A behavioural model in the bench predicts `rd_data` for every cycle.

// File: rtl/wf_mem_pkg.sv
package wf_mem_pkg;

   // Output behaviour of a storage port when it writes and reads in one cycle
   typedef enum logic [1:0] {
      PM_WRITE_FIRST = 2'd0,
      PM_READ_FIRST  = 2'd1,
      PM_NO_CHANGE   = 2'd2
   } port_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wf_addr_match.sv
module wf_addr_match #(
   parameter int ADDR_W = 6
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              b_we
);

   logic [ADDR_W-1:0] bit_eq;

   // Per-bit equality, reduced afterwards; sits on the address set-up path only
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign bit_eq[i] = ~(wr_addr[i] ^ rd_addr[i]);
   end

   assign b_we = wr_en & rd_en & (&bit_eq);

endmodule

// File: rtl/wf_ram_core.sv
module wf_ram_core
   import wf_mem_pkg::*;
#(
   parameter int         DATA_W = 16,
   parameter int         DEPTH  = 64,
   parameter int         ADDR_W = 6,
   parameter port_mode_e B_MODE = PM_WRITE_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   // port A: write only
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_din,
   // port B: read with optional write
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_din,
   output logic [DATA_W-1:0] b_dout
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              b_wr;

   assign b_wr = b_en & b_we;

   // Both ports share one process; a same-address double write carries equal data
   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_din;
      if (b_wr) mem[b_addr] <= b_din;
   end

   if (B_MODE == PM_WRITE_FIRST) begin : g_wf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_dout <= '0;
         else if (b_en) b_dout <= b_we ? b_din : mem[b_addr];
      end
   end else if (B_MODE == PM_READ_FIRST) begin : g_rf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_dout <= '0;
         else if (b_en) b_dout <= mem[b_addr];
      end
   end else begin : g_nc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            b_dout <= '0;
         else if (b_en && !b_we) b_dout <= mem[b_addr];
      end
   end

endmodule

// File: rtl/wf_sdp_mem.sv
module wf_sdp_mem
   import wf_mem_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam port_mode_e RD_PORT_MODE = PM_WRITE_FIRST;

   if (DATA_W < 1) begin : g_bad_width
      $error("wf_sdp_mem: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
      $error("wf_sdp_mem: DEPTH must be a power of two of at least 2");
   end
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_addr
      $error("wf_sdp_mem: ADDR_W must equal log2(DEPTH)");
   end

   logic b_we;

   wf_addr_match #(.ADDR_W(ADDR_W)) match_i (
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .b_we    (b_we)
   );

   wf_ram_core #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .B_MODE (RD_PORT_MODE)
   ) core_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_we   (wr_en),
      .a_addr (wr_addr),
      .a_din  (wr_data),
      .b_en   (rd_en),
      .b_we   (b_we),
      .b_addr (rd_addr),
      .b_din  (wr_data),
      .b_dout (rd_data)
   );

endmodule

// File: rtl/wf_sdp_mem_chk.sv
module wf_sdp_mem_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);

   logic [1:0] live_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_zero_chk: assert (rd_data == '0);
      end
   end

   // R4
   fwd_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && wr_addr == rd_addr) |=> (rd_data == $past(wr_data)));

   // R6
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en) |=> $stable(rd_data));

   // R7
   raw_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt >= 2'd1 && $past(wr_en) && rd_en && rd_addr == $past(wr_addr)
       && !(wr_en && wr_addr == rd_addr))
      |=> (rd_data == $past(wr_data, 2)));

endmodule

bind wf_sdp_mem wf_sdp_mem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/wf_sdp_mem_tb.sv
module wf_sdp_mem_tb_top;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b1;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   string cur_tag = "R1";
   string exp_tag = "R1";

   logic [DATA_W-1:0] model_mem [DEPTH];
   logic [DATA_W-1:0] exp_q = '0;

   always #5 clk = ~clk;

   wf_sdp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // Behavioural reference: the read sees a same-cycle write first, then the store updates
   always @(posedge clk) begin
      exp_tag = cur_tag;
      if (!rst_n) begin
         exp_q = '0;
      end else begin
         if (rd_en) begin
            if (wr_en && wr_addr == rd_addr) exp_q = wr_data;
            else                             exp_q = model_mem[rd_addr];
         end
         if (wr_en) model_mem[wr_addr] = wr_data;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (rd_data !== exp_q) begin
            fails++;
            $display("FAIL %s cycle %0d: rd_data=%h expected=%h", exp_tag, cycles, rd_data, exp_q);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: cycles=%0d expected completion before 50000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic step(input logic we, input int wa, input logic [DATA_W-1:0] wd,
                       input logic re, input int ra, input string tag);
      wr_en   = we;
      wr_addr = ADDR_W'(wa);
      wr_data = wd;
      rd_en   = re;
      rd_addr = ADDR_W'(ra);
      cur_tag = tag;
      @(negedge clk);
   endtask

   function automatic logic [DATA_W-1:0] fill_val(input int a);
      return DATA_W'(a * 257) ^ 16'h5A5A;
   endfunction

   initial begin
      #2 rst_n = 1'b0;
      @(negedge clk);
      // R1: reset holds output at zero
      repeat (3) step(1'b0, 0, '0, 1'b0, 0, "R1");
      rst_n = 1'b1;
      step(1'b0, 0, '0, 1'b0, 0, "R1");
      step(1'b0, 0, '0, 1'b0, 0, "R1");

      // R6: fill the store with reads disabled; output must hold zero
      for (int a = 0; a < DEPTH; a++) step(1'b1, a, fill_val(a), 1'b0, 0, "R6");

      // R2: read back every filled word
      for (int a = 0; a < DEPTH; a++) step(1'b0, 0, '0, 1'b1, a, "R2");
      // R3: descending reads, one cycle latency
      for (int a = DEPTH - 1; a >= 0; a -= 3) step(1'b0, 0, '0, 1'b1, a, "R3");

      // R4: same-address write and read in one cycle, then plain read-back
      for (int a = 5; a < 13; a++) step(1'b1, a, 16'hC000 + 16'(a), 1'b1, a, "R4");
      for (int a = 5; a < 13; a++) step(1'b0, 0, '0, 1'b1, a, "R4");
      step(1'b1, 20, 16'hAAAA, 1'b1, 20, "R4");
      step(1'b1, 20, 16'h5555, 1'b1, 20, "R4");
      step(1'b0, 0, '0, 1'b1, 20, "R4");

      // R8: write a neighbour during a read
      for (int a = 30; a < 38; a++) step(1'b1, a + 1, 16'hB0B0 ^ 16'(a), 1'b1, a, "R8");
      for (int a = 30; a < 39; a++) step(1'b0, 0, '0, 1'b1, a, "R8");

      // R5: disabled writes carrying matching address and junk data
      for (int a = 40; a < 46; a++) step(1'b0, a, 16'hDEAD, 1'b1, a, "R5");
      for (int a = 40; a < 46; a++) step(1'b0, 0, '0, 1'b1, a, "R5");

      // R7: write, then read the same address on the very next cycle
      for (int a = 50; a < 56; a++) begin
         step(1'b1, a, 16'h7000 + 16'(a), 1'b1, 0, "R7");
         step(1'b0, 0, '0, 1'b1, a, "R7");
      end

      // R6: read disabled while a write hits rd_addr; then confirm the store took it
      step(1'b0, 0, '0, 1'b1, 60, "R6");
      step(1'b1, 60, 16'h1234, 1'b0, 60, "R6");
      step(1'b1, 61, 16'h4321, 1'b0, 60, "R6");
      step(1'b0, 0, '0, 1'b0, 60, "R6");
      step(1'b0, 0, '0, 1'b1, 60, "R6");
      step(1'b0, 0, '0, 1'b1, 61, "R6");

      // R3: random mix over four addresses so collisions recur
      for (int n = 0; n < 600; n++) begin
         step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), DATA_W'($urandom),
              1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)), "R3");
      end

      step(1'b0, 0, '0, 1'b0, 0, "R3");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule